// File: doc/BRIEF.md
# Downlink Command Frame Checker

This block sits behind the downlink demodulator of a low-frequency contactless tag reader. When the demodulator has finished a frame it presents the captured bit buffer and the number of bits it received, together with a one-cycle end-of-frame strobe. The checker then selects the frame layout from the bit count. A 50-bit frame is the login layout. A 57-bit frame is the write-word layout. From that layout it pulls out the command code, the block address and the 32-bit payload.

The checker tests every protection field the frame carries. These are the leading zero, the parity bit over the command, and the address parity with its two pad zeros. It also tests the parity bit after each 8-bit data row, the column parity byte and the stop bit. All results appear together one cycle after the strobe, with a single-cycle valid pulse, and they hold until the next frame. A frame of any other length is reported only as a length error. Interpreting the payload, for example as a configuration word, is left to the consumer.

Top module: `dl_frame_check`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0 and every result output is 0 until the first strobe.
- R2: A strobe on `frm_end` in cycle t gives `res_valid` = 1 in cycle t+1 only. The results hold their values, and the frame inputs have no effect, for as long as `frm_end` stays low.
- R3: Bit 0 of the buffer is the first received bit. `res_cmd` is bits 1, 2 and 3 taken most significant bit first. `res_err_lead` is set when bit 0 is 1. `res_err_cmd_par` is set when bit 4 differs from the XOR of bits 1 to 3.
- R4: `res_err_cmd_code` is set when the command is 0, 3 or 7, and is clear for 1, 2, 4, 5 and 6.
- R5: In a 57-bit frame, `res_addr` is bits 5 to 8 with bit 5 as its least significant bit. `res_err_addr` is set when bit 9 or bit 10 is 1, or when bit 11 differs from the XOR of bits 5 to 10. In a 50-bit frame, `res_addr` is 0 and `res_err_addr` is 0.
- R6: The four data rows start at bits 5, 14, 23 and 32 of a 50-bit frame, and at bits 12, 21, 30 and 39 of a 57-bit frame. Each row is taken most significant bit first. The first row goes into `res_word[7:0]` and the last row into `res_word[31:24]`.
- R7: `res_err_row[k]` is set when the bit that follows row k differs from the XOR of that row's eight bits.
- R8: The eight bits after the last row parity bit (bits 41 to 48, or bits 48 to 55) form a byte taken most significant bit first. `res_err_col` is set when that byte differs from the XOR of the four data bytes.
- R9: `res_err_stop` is set when the last bit of the frame (bit 49, or bit 56) is 1.
- R10: A bit count other than 50 or 57 sets `res_err_len`. For such a frame the command, address, word and all other error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_end | input | 1 | End-of-frame strobe from the demodulator |
| frm_bits | input | 57 | Captured bits, index i = i-th received bit |
| frm_len | input | 7 | Number of bits received |
| res_valid | output | 1 | One-cycle pulse: results updated |
| res_cmd | output | 3 | Command code |
| res_addr | output | 4 | Block address (0 for the login layout) |
| res_word | output | 32 | Payload word |
| res_err_lead | output | 1 | Leading bit was not zero |
| res_err_cmd_par | output | 1 | Command parity mismatch |
| res_err_cmd_code | output | 1 | Command code is not a defined command |
| res_err_addr | output | 1 | Address parity or pad-bit error |
| res_err_row | output | 4 | Row parity mismatch, one bit per row |
| res_err_col | output | 1 | Column parity byte mismatch |
| res_err_stop | output | 1 | Stop bit was one |
| res_err_len | output | 1 | Bit count is neither 50 nor 57 |

## Verification
The bench corrupts one bit of each protection field in turn, in both layouts. A checker that used the wrong layout offsets would flag the wrong row, or would miss the stop bit at 49 against 56. One vector flips the first bit of a data row. That should raise the row flag and the column flag together and toggle word bit 7 or bit 31, so a byte that was assembled least significant bit first, or placed in the wrong lane of the word, shows up as a wrong word. Address 8 and a flipped pad zero catch a reversed address order and pad bits that were left out of the check. Lengths one below and one above each legal count, and a legal-looking buffer sent with a wrong count, catch a length compare that was off by one and stale fields that leak through on a length error.

// File: rtl/dlfc_pkg.sv
// Package: shared frame layout constants and command helpers for the
// downlink frame checker. Positions are counted in received-bit order,
// position 0 being the first bit off the air.
package dlfc_pkg;
    localparam int CMD_W        = 3;
    localparam int ADDR_W       = 4;
    localparam int ADDR_PAD     = 2;
    localparam int ROW_W        = 8;
    localparam int N_ROWS       = 4;
    localparam int WORD_W       = ROW_W * N_ROWS;
    localparam int ROW_SPAN     = ROW_W + 1;
    localparam int CMD_POS      = 1;
    localparam int CMD_PAR_POS  = CMD_POS + CMD_W;
    localparam int ADDR_POS     = CMD_PAR_POS + 1;
    localparam int ADDR_PAR_POS = ADDR_POS + ADDR_W + ADDR_PAD;
    localparam int HDR_W        = ADDR_PAR_POS + 1;
    localparam int BASE_LOGIN   = CMD_PAR_POS + 1;
    localparam int BASE_WRITE   = ADDR_PAR_POS + 1;
    localparam int COL_LOGIN    = BASE_LOGIN + N_ROWS * ROW_SPAN;
    localparam int COL_WRITE    = BASE_WRITE + N_ROWS * ROW_SPAN;
    localparam int STOP_LOGIN   = COL_LOGIN + ROW_W;
    localparam int STOP_WRITE   = COL_WRITE + ROW_W;
    localparam int LEN_LOGIN    = STOP_LOGIN + 1;
    localparam int LEN_WRITE    = STOP_WRITE + 1;

    typedef enum logic [CMD_W-1:0] {
        OP_LOGIN   = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd4,
        OP_DISABLE = 3'd5,
        OP_PROTECT = 3'd6
    } op_e;

    // True for the defined command codes.
    function automatic logic op_defined(input logic [CMD_W-1:0] c);
        case (c)
            OP_LOGIN, OP_WRITE, OP_READ, OP_DISABLE, OP_PROTECT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dlfc_row.sv
// Module: one data row of a downlink frame.
// Takes the row bits plus the parity bit that follows, in received order
// (slice[0] first). Assembles the byte most significant bit first and
// flags a parity bit that does not match the row.
// Assumes: purely combinational, slice is taken at the correct offset.
module dlfc_row #(
    parameter int ROW_W = 8
) (
    input  logic [ROW_W:0]   slice,
    output logic [ROW_W-1:0] data,
    output logic             par_err
);
    // Reverse received order into byte order: first bit becomes MSB.
    for (genvar i = 0; i < ROW_W; i++) begin : g_bit
        assign data[ROW_W-1-i] = slice[i];
    end

    // Row bits XOR parity bit is nonzero when they disagree.
    always_comb par_err = ^slice;
endmodule

// File: rtl/dlfc_col.sv
// Module: column parity check of a downlink frame.
// Compares the received column byte (received order, first bit = MSB)
// against the XOR of all data rows.
// Assumes: purely combinational; word holds row k in lane k.
module dlfc_col #(
    parameter int ROW_W  = 8,
    parameter int N_ROWS = 4
) (
    input  logic [ROW_W*N_ROWS-1:0] word,
    input  logic [ROW_W-1:0]        rx_slice,
    output logic                    col_err
);
    logic [ROW_W-1:0] rx_byte;
    logic [ROW_W-1:0] calc;

    for (genvar i = 0; i < ROW_W; i++) begin : g_rev
        assign rx_byte[ROW_W-1-i] = rx_slice[i];
    end

    // Fold the rows into one byte with XOR.
    always_comb begin
        calc = '0;
        for (int k = 0; k < N_ROWS; k++) begin
            calc = calc ^ word[k*ROW_W +: ROW_W];
        end
    end

    // Mismatch between received and computed column byte.
    always_comb col_err = (rx_byte != calc);
endmodule

// File: rtl/dlfc_hdr.sv
// Module: header fields of a downlink frame.
// Decodes the leading zero, the command with its parity, and (write
// layout only) the address with its pad zeros and parity.
// Assumes: purely combinational; hbits[0] is the first received bit.
module dlfc_hdr
    import dlfc_pkg::*;
(
    input  logic [HDR_W-1:0]  hbits,
    input  logic              is_write,
    output logic [CMD_W-1:0]  cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              err_lead,
    output logic              err_cmd_par,
    output logic              err_cmd_code,
    output logic              err_addr
);
    // Command arrives most significant bit first.
    for (genvar i = 0; i < CMD_W; i++) begin : g_cmd
        assign cmd[CMD_W-1-i] = hbits[CMD_POS+i];
    end

    // Address arrives least significant bit first; absent in login layout.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        assign addr[i] = is_write & hbits[ADDR_POS+i];
    end

    // Leading bit and command checks.
    always_comb begin
        err_lead     = hbits[0];
        err_cmd_par  = ^hbits[CMD_PAR_POS:CMD_POS];
        err_cmd_code = !op_defined(cmd);
    end

    // Address parity over address plus pads, and pads must be zero.
    always_comb begin
        err_addr = is_write &
                   ((^hbits[ADDR_PAR_POS:ADDR_POS]) |
                    (|hbits[ADDR_PAR_POS-1 -: ADDR_PAD]));
    end
endmodule

// File: rtl/dl_frame_check.sv
// Module: downlink command frame checker (top).
// On an end-of-frame strobe, selects the login or write-word layout from
// the bit count, extracts command, address and payload, checks every
// parity field and the stop bit, and registers all results with a
// one-cycle valid pulse. Results hold until the next strobe.
// Assumes: frm_bits and frm_len are stable in the strobe cycle;
// synchronous active-low reset.
module dl_frame_check
    import dlfc_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_end,
    input  logic [LEN_WRITE-1:0] frm_bits,
    input  logic [LEN_W-1:0]     frm_len,
    output logic                 res_valid,
    output logic [CMD_W-1:0]     res_cmd,
    output logic [ADDR_W-1:0]    res_addr,
    output logic [WORD_W-1:0]    res_word,
    output logic                 res_err_lead,
    output logic                 res_err_cmd_par,
    output logic                 res_err_cmd_code,
    output logic                 res_err_addr,
    output logic [N_ROWS-1:0]    res_err_row,
    output logic                 res_err_col,
    output logic                 res_err_stop,
    output logic                 res_err_len
);
    localparam int N_LAY = 2;

    logic                    is_login, is_write, len_ok;
    logic [N_LAY*WORD_W-1:0] word_all;
    logic [N_LAY*N_ROWS-1:0] rerr_all;
    logic [N_LAY-1:0]        cerr_all;
    logic [CMD_W-1:0]        h_cmd;
    logic [ADDR_W-1:0]       h_addr;
    logic                    h_lead, h_cpar, h_code, h_addr_err;
    logic [WORD_W-1:0]       sel_word;
    logic [N_ROWS-1:0]       sel_rerr;
    logic                    sel_cerr, sel_stop;

    // Layout selection from the received bit count.
    always_comb begin
        is_login = (frm_len == LEN_W'(LEN_LOGIN));
        is_write = (frm_len == LEN_W'(LEN_WRITE));
        len_ok   = is_login | is_write;
    end

    dlfc_hdr u_hdr (
        .hbits        (frm_bits[HDR_W-1:0]),
        .is_write     (is_write),
        .cmd          (h_cmd),
        .addr         (h_addr),
        .err_lead     (h_lead),
        .err_cmd_par  (h_cpar),
        .err_cmd_code (h_code),
        .err_addr     (h_addr_err)
    );

    // One row/column checker set per layout (0 = login, 1 = write word).
    for (genvar L = 0; L < N_LAY; L++) begin : g_lay
        localparam int BASE = (L == 0) ? BASE_LOGIN : BASE_WRITE;
        localparam int COL  = BASE + N_ROWS * ROW_SPAN;
        for (genvar k = 0; k < N_ROWS; k++) begin : g_row
            dlfc_row #(.ROW_W(ROW_W)) u_row (
                .slice   (frm_bits[BASE + k*ROW_SPAN +: ROW_SPAN]),
                .data    (word_all[(L*N_ROWS + k)*ROW_W +: ROW_W]),
                .par_err (rerr_all[L*N_ROWS + k])
            );
        end
        dlfc_col #(.ROW_W(ROW_W), .N_ROWS(N_ROWS)) u_col (
            .word     (word_all[L*WORD_W +: WORD_W]),
            .rx_slice (frm_bits[COL +: ROW_W]),
            .col_err  (cerr_all[L])
        );
    end

    // Pick the results of the layout that matches the count.
    always_comb begin
        if (is_write) begin
            sel_word = word_all[WORD_W +: WORD_W];
            sel_rerr = rerr_all[N_ROWS +: N_ROWS];
            sel_cerr = cerr_all[1];
            sel_stop = frm_bits[STOP_WRITE];
        end else begin
            sel_word = word_all[0 +: WORD_W];
            sel_rerr = rerr_all[0 +: N_ROWS];
            sel_cerr = cerr_all[0];
            sel_stop = frm_bits[STOP_LOGIN];
        end
    end

    // Result register: loads on the strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid        <= 1'b0;
            res_cmd          <= '0;
            res_addr         <= '0;
            res_word         <= '0;
            res_err_lead     <= 1'b0;
            res_err_cmd_par  <= 1'b0;
            res_err_cmd_code <= 1'b0;
            res_err_addr     <= 1'b0;
            res_err_row      <= '0;
            res_err_col      <= 1'b0;
            res_err_stop     <= 1'b0;
            res_err_len      <= 1'b0;
        end else begin
            res_valid <= frm_end;
            if (frm_end) begin
                res_err_len      <= !len_ok;
                res_cmd          <= len_ok ? h_cmd      : '0;
                res_addr         <= len_ok ? h_addr     : '0;
                res_word         <= len_ok ? sel_word   : '0;
                res_err_lead     <= len_ok & h_lead;
                res_err_cmd_par  <= len_ok & h_cpar;
                res_err_cmd_code <= len_ok & h_code;
                res_err_addr     <= len_ok & h_addr_err;
                res_err_row      <= len_ok ? sel_rerr   : '0;
                res_err_col      <= len_ok & sel_cerr;
                res_err_stop     <= len_ok & sel_stop;
            end
        end
    end

    // R2: a strobe always yields a valid pulse in the next cycle.
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |=> res_valid);

    // R2: without a strobe the results hold and no pulse is given.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_end |=> (!res_valid && $stable(res_word) && $stable(res_cmd)
                      && $stable(res_err_row)));

    // R10: a length error clears every other field.
    assert_len_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err_len) |-> (res_word == '0 && res_cmd == '0 &&
            res_addr == '0 && res_err_row == '0 && !res_err_col &&
            !res_err_stop && !res_err_addr && !res_err_lead));

    // R5: the login layout reports no address.
    assert_login_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && is_login) |=> (res_addr == '0 && !res_err_addr));

    // R4: a flagged command code is never one of the defined commands.
    assert_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err_cmd_code) |->
            !(res_cmd inside {3'd1, 3'd2, 3'd4, 3'd5, 3'd6}));
endmodule

// File: tb/sim_dl_frame_check.sv
`timescale 1ns/1ps
module sim_dl_frame_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_end = 1'b0;
    logic [56:0] frm_bits = '0;
    logic [6:0]  frm_len = '0;
    logic        res_valid;
    logic [2:0]  res_cmd;
    logic [3:0]  res_addr;
    logic [31:0] res_word;
    logic        res_err_lead, res_err_cmd_par, res_err_cmd_code, res_err_addr;
    logic [3:0]  res_err_row;
    logic        res_err_col, res_err_stop, res_err_len;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    dl_frame_check u0 (
        .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_bits(frm_bits),
        .frm_len(frm_len), .res_valid(res_valid), .res_cmd(res_cmd),
        .res_addr(res_addr), .res_word(res_word), .res_err_lead(res_err_lead),
        .res_err_cmd_par(res_err_cmd_par), .res_err_cmd_code(res_err_cmd_code),
        .res_err_addr(res_err_addr), .res_err_row(res_err_row),
        .res_err_col(res_err_col), .res_err_stop(res_err_stop),
        .res_err_len(res_err_len)
    );

    // Error vector: [0] lead, [1] cmd parity, [2] cmd code, [3] addr,
    // [7:4] row 3..0, [8] column, [9] stop, [10] length.
    typedef struct packed {
        logic [6:0]  len;
        logic [2:0]  cmd;
        logic [3:0]  addr;
        logic [31:0] word;
        logic [7:0]  flip;   // bit to corrupt, 8'hFF = none
        logic [31:0] wmask;  // payload bits changed by the flip
        logic [10:0] err;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{7'd57, 3'd2, 4'h4, 32'h12345678, 8'hFF, 32'h0,        11'h000, 8'd6}, // R6 clean write
        '{7'd50, 3'd1, 4'h0, 32'hDEADBEEF, 8'hFF, 32'h0,        11'h000, 8'd6}, // R6 clean login
        '{7'd57, 3'd2, 4'h9, 32'hA5A50F0F, 8'd0,  32'h0,        11'h001, 8'd3}, // R3 lead
        '{7'd57, 3'd4, 4'h1, 32'h00FF00FF, 8'd4,  32'h0,        11'h002, 8'd3}, // R3 cmd parity
        '{7'd57, 3'd2, 4'h3, 32'hCAFEF00D, 8'd11, 32'h0,        11'h008, 8'd5}, // R5 addr parity
        '{7'd57, 3'd2, 4'h6, 32'h13579BDF, 8'd10, 32'h0,        11'h008, 8'd5}, // R5 pad zero
        '{7'd57, 3'd2, 4'hF, 32'h2468ACE0, 8'd29, 32'h0,        11'h020, 8'd7}, // R7 row 1
        '{7'd50, 3'd1, 4'h0, 32'h0F1E2D3C, 8'd40, 32'h0,        11'h080, 8'd7}, // R7 row 3
        '{7'd57, 3'd2, 4'h2, 32'h11223344, 8'd50, 32'h0,        11'h100, 8'd8}, // R8 column
        '{7'd50, 3'd1, 4'h0, 32'h55AA55AA, 8'd49, 32'h0,        11'h200, 8'd9}, // R9 stop login
        '{7'd57, 3'd3, 4'h1, 32'h00000000, 8'hFF, 32'h0,        11'h004, 8'd4}, // R4 code 3
        '{7'd50, 3'd7, 4'h0, 32'hFFFFFFFF, 8'hFF, 32'h0,        11'h004, 8'd4}, // R4 code 7
        '{7'd57, 3'd0, 4'h0, 32'h00000000, 8'hFF, 32'h0,        11'h004, 8'd4}, // R4 code 0
        '{7'd50, 3'd1, 4'h0, 32'h00000001, 8'd5,  32'h00000080, 11'h110, 8'd6}, // R6 MSB first
        '{7'd50, 3'd5, 4'h0, 32'h80000000, 8'hFF, 32'h0,        11'h000, 8'd4}, // R4 code 5
        '{7'd57, 3'd6, 4'h8, 32'h7F7F7F7F, 8'hFF, 32'h0,        11'h000, 8'd5}, // R5 addr LSB first
        '{7'd57, 3'd2, 4'h4, 32'h01020304, 8'd39, 32'h80000000, 11'h180, 8'd6}  // R6 last lane
    };

    // Encoder: build a correctly protected frame from its fields.
    function automatic logic [56:0] build(input int len, input logic [2:0] cmd,
                                          input logic [3:0] addr,
                                          input logic [31:0] word);
        logic [56:0] b;
        logic [7:0]  col;
        int          base;
        b = '0;
        b[1] = cmd[2]; b[2] = cmd[1]; b[3] = cmd[0];
        b[4] = ^cmd;
        base = 5;
        if (len == 57) begin
            for (int i = 0; i < 4; i++) b[5+i] = addr[i];
            b[11] = ^addr;
            base = 12;
        end
        col = '0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] by;
            by = word[8*k +: 8];
            col = col ^ by;
            for (int i = 0; i < 8; i++) b[base + 9*k + i] = by[7-i];
            b[base + 9*k + 8] = ^by;
        end
        for (int i = 0; i < 8; i++) b[base + 36 + i] = col[7-i];
        return b;
    endfunction

    function automatic logic [10:0] got_err();
        return {res_err_len, res_err_stop, res_err_col, res_err_row,
                res_err_addr, res_err_cmd_code, res_err_cmd_par, res_err_lead};
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Present one frame with a strobe; return at the negedge after capture.
    task automatic send(input int len, input logic [56:0] bits);
        @(negedge clk);
        frm_end  = 1'b1;
        frm_len  = 7'(len);
        frm_bits = bits;
        @(negedge clk);
        frm_end  = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        tests++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [56:0] fb;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", {63'd0, res_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "outputs after reset",
              {res_valid, res_cmd, res_addr, res_word, got_err()}, 64'd0);

        // Vector table: R3..R9 across both layouts.
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string rq;
            t  = VECS[v];
            fb = build(int'(t.len), t.cmd, t.addr, t.word);
            if (t.flip != 8'hFF) fb[t.flip] = ~fb[t.flip];
            send(int'(t.len), fb);
            rq = $sformatf("R%0d vec%0d", t.rq, v);
            check(rq, "valid/cmd/addr", {res_valid, res_cmd, res_addr},
                  {1'b1, t.cmd, (t.len == 7'd57) ? t.addr : 4'h0});
            check(rq, "word", {32'd0, res_word}, {32'd0, t.word ^ t.wmask});
            check(rq, "errors", {53'd0, got_err()}, {53'd0, t.err});
        end

        // R2: single pulse, then hold while inputs change without strobe.
        send(57, build(57, 3'd2, 4'h5, 32'hBEEF0123));
        check("R2", "pulse high", {63'd0, res_valid}, 64'd1);
        @(negedge clk);
        check("R2", "pulse low", {63'd0, res_valid}, 64'd0);
        frm_bits = '1;
        frm_len  = 7'd50;
        repeat (3) @(negedge clk);
        check("R2", "hold word", {res_valid, res_cmd, res_addr, res_word},
              {1'b0, 3'd2, 4'h5, 32'hBEEF0123});
        check("R2", "hold errors", {53'd0, got_err()}, 64'd0);

        // R10: lengths around and away from the legal counts.
        begin
            int bad [6] = '{0, 49, 51, 56, 58, 127};
            for (int i = 0; i < 6; i++) begin
                send(bad[i], build(57, 3'd2, 4'hA, 32'hFFFFFFFF) | 57'h1);
                check("R10", $sformatf("len %0d", bad[i]),
                      {res_valid, res_cmd, res_addr, res_word, got_err()},
                      {1'b1, 3'd0, 4'd0, 32'd0, 11'h400});
            end
        end

        // R9: stop bit of the write layout, right after a length error.
        fb = build(57, 3'd2, 4'h1, 32'h0BADCAFE);
        fb[56] = 1'b1;
        send(57, fb);
        check("R9", "stop write", {53'd0, got_err()}, {53'd0, 11'h200});
        check("R9", "word write", {32'd0, res_word}, {32'd0, 32'h0BADCAFE});

        // R1: reset mid-run clears held results.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset clears", {res_valid, res_cmd, res_addr, res_word,
              got_err()}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule